// File: doc/BRIEF.md
# Bus-Snooping Nibble RAM with Display Read Ports

This block models a small RAM device for a 4-bit microcomputer bus. It stores four registers. Each register has sixteen main characters and four status characters, and every character is one 4-bit nibble. The device also drives one 4-bit output port. The shared bus carries instruction nibbles and data nibbles in an eight-phase cycle, and the device receives no read or write strobe. It keeps track of the phase, captures the low opcode nibble as the instruction is fetched, and decodes from that nibble the action to take in the execute phases.

Several devices can share one bus. Each device compares the chip number from the last register-select command against its own static chip-ID input, and only a matching device acts on accesses. Every register also has its own read address and data output for a display engine. These display reads are combinational, they run concurrently with bus traffic, and they show a bus write from the clock edge at which it is stored.

Top module: `nram_snoop`

## Requirements
- R1: A high `sync_i` in a cycle makes the next cycle phase A1. Without `sync_i` the phase steps one place per clock through A1, A2, A3, M1, M2, X1, X2, X3 (codes 0 to 7). Reset leaves the phase at X3, so the first cycle after reset is A1.
- R2: The device acts on an opcode only when `cmd_i` was high in the M1 phase of the same cycle. With `cmd_i` low, the opcode has no effect on storage, port or bus.
- R3: Opcode 0x2 is register select. The X2 nibble gives the chip number in bits [3:2] and the register in bits [1:0], and the X3 nibble gives the main character index 0 to 15. Every device latches it, whatever its chip ID.
- R4: Opcode 0x0 writes the X2 bus nibble into the selected main character of the selected register.
- R5: Opcode 0x8 drives the selected main character on `data_o` with `data_oe_o` high during X2 only. `data_oe_o` is low in all other phases.
- R6: Opcodes 0x4+k write status character k (k = 0..3) of the selected register from the X2 nibble. Opcodes 0xC+k drive status character k in X2.
- R7: Opcode 0x1 loads the X2 nibble into `port_o`. The port holds its value until the next port write.
- R8: For each register r, `disp_data_o[4r+3:4r]` is combinational in `disp_addr_i[5r+4:5r]`. Addresses 0..15 return main characters, 16..19 return status characters 0..3, and 20..31 return 0.
- R9: When the latched chip number differs from `chip_id_i`, write, read, status and port opcodes have no effect, and `data_oe_o` stays low.
- R10: Reset (active-low, asynchronous) clears every character and the port to 0 and releases the bus.
- R11: Opcodes 0x3 and 0x9 to 0xB have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Cycle marker; next cycle is A1 |
| cmd_i | input | 1 | Marks the fetched instruction as a RAM/IO command (sampled in M1) |
| data_i | input | 4 | Bus nibble in |
| data_o | output | 4 | Bus nibble out |
| data_oe_o | output | 1 | Bus drive enable |
| chip_id_i | input | 2 | Static chip number of this device |
| port_o | output | 4 | Output port |
| disp_addr_i | input | 20 | Four 5-bit display read addresses, register 0 in the low bits |
| disp_data_o | output | 16 | Four 4-bit display read nibbles, register 0 in the low bits |

## Verification
The stimulus has four parts. It writes and reads back single characters, status characters and the port while the chip number matches. It repeats those commands with `cmd_i` low, with a non-matching chip number, and with the unused opcodes, so a decoder that ignores the command line, the chip match or the opcode gaps shows a difference. A fill loop spreads many values over all registers and characters. The display addresses walk through main, status and out-of-range values on every cycle, so that a wrong address map, a wrong register mapping or a late write shows on the display outputs. A behavioural model of the bus cycle is compared on every clock with the drive enable, the driven data, the port and all four display nibbles, which places each effect in the phase where it must occur.

// File: rtl/nram_pkg.sv
package nram_pkg;
  typedef enum logic [2:0] {
    PH_A1, PH_A2, PH_A3, PH_M1, PH_M2, PH_X1, PH_X2, PH_X3
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_SEL, OP_WR_MAIN, OP_RD_MAIN, OP_WR_STAT, OP_RD_STAT, OP_PORT
  } op_e;

  function automatic op_e decode_opa(input logic [3:0] opa);
    op_e k;
    casez (opa)
      4'b0000: k = OP_WR_MAIN;
      4'b0001: k = OP_PORT;
      4'b0010: k = OP_SEL;
      4'b01??: k = OP_WR_STAT;
      4'b1000: k = OP_RD_MAIN;
      4'b11??: k = OP_RD_STAT;
      default: k = OP_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/nram_phase.sv
module nram_phase
  import nram_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sync_i,
  output phase_e phase_o
);
  phase_e phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= PH_X3;
    else if (sync_i) phase_q <= PH_A1;
    else             phase_q <= phase_e'(phase_q + 3'd1);
  end

  assign phase_o = phase_q;

  AST_SYNC_TO_A1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> phase_q == PH_A1); // R1
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> phase_q == phase_e'($past(phase_q) + 3'd1)); // R1
endmodule

// File: rtl/nram_decode.sv
module nram_decode
  import nram_pkg::*;
#(
  parameter int DW         = 4,
  parameter int CW         = 2,
  parameter int NUM_REGS   = 4,
  parameter int MAIN_CHARS = 16,
  parameter int STAT_CHARS = 4,
  localparam int RW  = $clog2(NUM_REGS),
  localparam int CIW = $clog2(MAIN_CHARS),
  localparam int AW  = $clog2(MAIN_CHARS + STAT_CHARS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  phase_e        phase_i,
  input  logic          cmd_i,
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] chip_id_i,
  output logic          we_o,
  output logic          rd_en_o,
  output logic          port_we_o,
  output logic [RW-1:0] acc_reg_o,
  output logic [AW-1:0] acc_addr_o
);
  logic           cmd_q, op_valid_q;
  logic [DW-1:0]  opa_q;
  logic [CW-1:0]  sel_chip_q;
  logic [RW-1:0]  sel_reg_q;
  logic [CIW-1:0] sel_char_q;
  op_e            op;
  logic           act;

  assign op = decode_opa(opa_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= 1'b0;
      op_valid_q <= 1'b0;
      opa_q      <= '0;
      sel_chip_q <= '0;
      sel_reg_q  <= '0;
      sel_char_q <= '0;
    end else begin
      if (phase_i == PH_M1) cmd_q <= cmd_i;
      if (phase_i == PH_M2) begin
        op_valid_q <= cmd_q;
        opa_q      <= data_i;
      end
      // select is broadcast: every device latches it
      if (op_valid_q && op == OP_SEL) begin
        if (phase_i == PH_X2) begin
          sel_chip_q <= data_i[DW-1 -: CW];
          sel_reg_q  <= data_i[RW-1:0];
        end
        if (phase_i == PH_X3) sel_char_q <= data_i[CIW-1:0];
      end
    end
  end

  assign act       = op_valid_q && (sel_chip_q == chip_id_i) && (phase_i == PH_X2);
  assign we_o      = act && (op == OP_WR_MAIN || op == OP_WR_STAT);
  assign rd_en_o   = act && (op == OP_RD_MAIN || op == OP_RD_STAT);
  assign port_we_o = act && (op == OP_PORT);
  assign acc_reg_o = sel_reg_q;

  always_comb begin
    if (op == OP_WR_STAT || op == OP_RD_STAT)
      acc_addr_o = AW'(MAIN_CHARS) + AW'(opa_q[1:0]);
    else
      acc_addr_o = AW'(sel_char_q);
  end
endmodule

// File: rtl/nram_regfile.sv
module nram_regfile #(
  parameter int DW       = 4,
  parameter int NUM_REGS = 4,
  parameter int NCHAR    = 20,
  localparam int RW = $clog2(NUM_REGS),
  localparam int AW = $clog2(NCHAR)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [RW-1:0]          reg_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  input  logic [NUM_REGS*AW-1:0] disp_addr_i,
  output logic [NUM_REGS*DW-1:0] disp_data_o
);
  logic [DW-1:0] bus_rd [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DW-1:0] mem_q [NCHAR];
    logic [DW-1:0] disp_rd, bus_row;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NCHAR; i++) mem_q[i] <= '0;
      end else if (we_i && reg_i == RW'(g)) begin
        for (int i = 0; i < NCHAR; i++)
          if (addr_i == AW'(i)) mem_q[i] <= wdata_i;
      end
    end

    // out-of-range addresses read as zero
    always_comb begin
      disp_rd = '0;
      bus_row = '0;
      for (int i = 0; i < NCHAR; i++) begin
        if (disp_addr_i[g*AW +: AW] == AW'(i)) disp_rd = mem_q[i];
        if (addr_i == AW'(i))                  bus_row = mem_q[i];
      end
    end

    assign bus_rd[g]               = bus_row;
    assign disp_data_o[g*DW +: DW] = disp_rd;

    AST_DISP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(disp_addr_i[g*AW +: AW]) && !$past(we_i && reg_i == RW'(g))
      |-> $stable(disp_data_o[g*DW +: DW])); // R8
  end

  assign rdata_o = bus_rd[reg_i];
endmodule

// File: rtl/nram_snoop.sv
module nram_snoop
  import nram_pkg::*;
#(
  parameter int CW         = 2,
  parameter int NUM_REGS   = 4,
  parameter int MAIN_CHARS = 16,
  parameter int STAT_CHARS = 4,
  localparam int DW    = 4,
  localparam int NCHAR = MAIN_CHARS + STAT_CHARS,
  localparam int RW    = $clog2(NUM_REGS),
  localparam int AW    = $clog2(NCHAR)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sync_i,
  input  logic                   cmd_i,
  input  logic [DW-1:0]          data_i,
  output logic [DW-1:0]          data_o,
  output logic                   data_oe_o,
  input  logic [CW-1:0]          chip_id_i,
  output logic [DW-1:0]          port_o,
  input  logic [NUM_REGS*AW-1:0] disp_addr_i,
  output logic [NUM_REGS*DW-1:0] disp_data_o
);
  phase_e        phase;
  logic          we, rd_en, port_we;
  logic [RW-1:0] acc_reg;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] rdata, port_q;

  nram_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .phase_o(phase)
  );

  nram_decode #(
    .DW(DW), .CW(CW), .NUM_REGS(NUM_REGS),
    .MAIN_CHARS(MAIN_CHARS), .STAT_CHARS(STAT_CHARS)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .cmd_i     (cmd_i),
    .data_i    (data_i),
    .chip_id_i (chip_id_i),
    .we_o      (we),
    .rd_en_o   (rd_en),
    .port_we_o (port_we),
    .acc_reg_o (acc_reg),
    .acc_addr_o(acc_addr)
  );

  nram_regfile #(.DW(DW), .NUM_REGS(NUM_REGS), .NCHAR(NCHAR)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we),
    .reg_i      (acc_reg),
    .addr_i     (acc_addr),
    .wdata_i    (data_i),
    .rdata_o    (rdata),
    .disp_addr_i(disp_addr_i),
    .disp_data_o(disp_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      port_q <= '0;
    else if (port_we) port_q <= data_i;
  end

  assign port_o    = port_q;
  assign data_oe_o = rd_en;
  assign data_o    = rd_en ? rdata : '0;

  AST_OE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |=> !data_oe_o); // R5
  AST_OE_BEFORE_X3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |=> phase == PH_X3); // R5
  AST_PORT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_we |=> $stable(port_o)); // R7
endmodule

// File: tb/nram_snoop_test.sv
`timescale 1ns/1ps
module nram_snoop_test;
  localparam logic [1:0] ID = 2'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_i = 1'b0, cmd_i = 1'b0;
  logic [3:0]  data_i = 4'h0;
  logic [3:0]  data_o, port_o;
  logic        data_oe_o;
  logic [19:0] disp_addr = '0;
  logic [15:0] disp_data;

  int errors = 0, checks = 0, cyc_no = 0;
  string tag = "R10";

  // behavioural model state
  int m_mem [4][20];
  int m_port = 0, m_chip = 0, m_reg = 0, m_char = 0, m_opa = 0;
  bit m_cmd = 0, m_valid = 0;

  always #4 clk = ~clk;

  nram_snoop uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync_i), .cmd_i(cmd_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o),
    .chip_id_i(ID), .port_o(port_o),
    .disp_addr_i(disp_addr), .disp_data_o(disp_data)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int mval(input int r, input int a);
    return (a < 20) ? m_mem[r][a] : 0;
  endfunction

  function automatic bit is_read(input int o);
    return (o == 8) || (o >= 12);
  endfunction

  task automatic compare_all(input int p);
    bit exp_oe;
    int exp_d;
    exp_oe = (p == 6) && m_valid && is_read(m_opa) && (m_chip == int'(ID));
    exp_d  = (m_opa == 8) ? mval(m_reg, m_char) : mval(m_reg, 16 + (m_opa & 3));
    check(data_oe_o == exp_oe, "R5/R1 bus enable", int'(data_oe_o), int'(exp_oe));
    if (exp_oe) check(int'(data_o) == exp_d, "R5/R6 read data", int'(data_o), exp_d);
    check(int'(port_o) == m_port, "R7 port", int'(port_o), m_port);
    for (int r = 0; r < 4; r++) begin
      int a;
      a = int'(disp_addr[r*5 +: 5]);
      check(int'(disp_data[r*4 +: 4]) == mval(r, a), "R8 display", int'(disp_data[r*4 +: 4]), mval(r, a));
    end
  endtask

  // one phase: compare state, drive inputs, predict the coming edge
  task automatic step(input int p, input bit c, input int opa, input int x2, input int x3);
    @(negedge clk);
    compare_all(p);
    if (p == 0) begin
      cyc_no++;
      for (int r = 0; r < 4; r++) disp_addr[r*5 +: 5] = 5'((cyc_no * 3 + r * 7) % 24);
    end
    sync_i = (p == 7);
    cmd_i  = (p == 3) ? c : 1'b0;
    data_i = (p == 4) ? 4'(opa) : (p == 6) ? 4'(x2) : (p == 7) ? 4'(x3) : 4'h0;
    case (p)
      3: m_cmd = c;
      4: begin m_valid = m_cmd; m_opa = opa; end
      6: if (m_valid) begin
           if (m_opa == 2) begin m_chip = (x2 >> 2) & 3; m_reg = x2 & 3; end
           else if (m_chip == int'(ID)) begin
             if (m_opa == 0) m_mem[m_reg][m_char] = x2;
             else if (m_opa == 1) m_port = x2;
             else if (m_opa >= 4 && m_opa <= 7) m_mem[m_reg][16 + (m_opa & 3)] = x2;
           end
         end
      7: if (m_valid && m_opa == 2) m_char = x3;
      default: ;
    endcase
  endtask

  task automatic bus_cycle(input bit c, input int opa, input int x2, input int x3);
    for (int p = 0; p < 8; p++) step(p, c, opa, x2, x3);
  endtask

  task automatic sel(input int chip, input int rg, input int ch);
    bus_cycle(1'b1, 2, (chip << 2) | rg, ch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++) for (int a = 0; a < 20; a++) m_mem[r][a] = 0;
    repeat (3) @(negedge clk);
    tag = "R10";
    compare_all(0);
    rst_n = 1'b1;
    @(negedge clk);
    sync_i = 1'b1;

    tag = "R3/R4/R5";
    sel(1, 0, 3);
    bus_cycle(1'b1, 0, 4'hA, 0);
    bus_cycle(1'b1, 8, 0, 0);
    sel(1, 2, 15);
    bus_cycle(1'b1, 0, 4'h5, 0);
    bus_cycle(1'b1, 8, 0, 0);

    tag = "R6";
    for (int k = 0; k < 4; k++) bus_cycle(1'b1, 4 + k, 9 + k, 0);
    for (int k = 0; k < 4; k++) bus_cycle(1'b1, 12 + k, 0, 0);

    tag = "R7";
    bus_cycle(1'b1, 1, 4'h6, 0);
    bus_cycle(1'b0, 0, 0, 0);

    tag = "R2";
    bus_cycle(1'b0, 0, 4'hF, 0);
    bus_cycle(1'b0, 1, 4'h3, 0);
    bus_cycle(1'b0, 8, 0, 0);
    bus_cycle(1'b0, 2, 4'h3, 9);
    bus_cycle(1'b1, 8, 0, 0);

    tag = "R11";
    bus_cycle(1'b1, 3, 4'h7, 0);
    for (int o = 9; o < 12; o++) bus_cycle(1'b1, o, 4'hE, 0);
    bus_cycle(1'b1, 8, 0, 0);

    tag = "R9";
    sel(2, 2, 15);
    bus_cycle(1'b1, 0, 4'hC, 0);
    bus_cycle(1'b1, 5, 4'hC, 0);
    bus_cycle(1'b1, 1, 4'hC, 0);
    bus_cycle(1'b1, 8, 0, 0);
    bus_cycle(1'b1, 13, 0, 0);
    sel(1, 2, 15);
    bus_cycle(1'b1, 8, 0, 0);

    tag = "R4/R8 fill";
    for (int i = 0; i < 64; i++) begin
      sel(1, i % 4, (i * 7) % 16);
      bus_cycle(1'b1, 0, (i * 11 + 3) % 16, 0);
      bus_cycle(1'b1, 8, 0, 0);
      if (i % 8 == 0) bus_cycle(1'b1, 4 + (i % 4), (i * 5) % 16, 0);
    end
    tag = "R1 idle";
    bus_cycle(1'b0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule